// File: doc/BRIEF.md
# Variable-Speed Scrolling Track Position Counter

This block sets how fast a dashed track scrolls across the screen. A free-running position counter, clocked by the system clock, normally wraps after exactly one line length (384 counts). The dashes then fall on the same pixels on every line, so the track stays still. When the counter instead wraps one count early (after 383 counts), the pattern moves one pixel to the left. How often that happens sets the scroll speed.

A 4-bit rate generator decides when early wraps are requested. It steps once per frame. When it reaches zero it reloads with 15 minus the leader-position code and requests one early wrap. A leader far from the finish (low code) therefore gives rare early wraps and a slow scroll. A leader about to finish (code 15) gives one early wrap every frame. The request waits until the next line-start strobe and is then used at the first wrap point of that line. The block also outputs a track-pixel enable, which is taken from the counter to draw the dashes.

Top module: `scroll_pos_counter`

## Requirements
- R1: While `rstN` is low, `trackPos` is 0, the rate counter is 0 and no early wrap is pending or armed. `trackPix` is therefore 1.
- R2: On each clock edge out of reset, `trackPos` increases by 1, except at a wrap, where it becomes 0.
- R3: When no early wrap is armed, `trackPos` goes from 383 to 0, which gives 384 counts per cycle.
- R4: When an early wrap is armed, `trackPos` goes from 382 to 0, which gives 383 counts. This disarms it, so exactly one early wrap happens per arming.
- R5: On a `frameStart` pulse the rate counter is checked. If it is 0, it reloads with 15 − `posCode` and one early wrap becomes pending. Otherwise it decrements by 1. With a fixed code p, early wraps are therefore requested on one frame in every 16 − p: code 0 gives every 16 frames, code 15 gives every frame.
- R6: A `lineStart` pulse moves the pending request into the armed state and clears the pending request. A request becomes pending at a `frameStart`, is armed at the next `lineStart`, and is used in that line.
- R7: When `lineStart` and a rate-counter terminal count fall in the same cycle, the armed state takes the pending value from before that cycle. The new request stays pending until the following `lineStart`.
- R8: `trackPix` is 1 exactly when bits [4:2] of `trackPos` are all 0.
- R9: `posCode` is sampled only at a reload. A change of `posCode` partway through a rate period does not alter when the next early wrap is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineStart | input | 1 | One-cycle strobe at the start of each line |
| frameStart | input | 1 | One-cycle strobe once per frame |
| posCode | input | 4 | Leader position, 0 = far from finish, 15 = at finish |
| trackPos | output | 9 | Current position counter value |
| trackPix | output | 1 | Track pixel enable (dash) |

## Verification
The bench counts early wraps, seen at the ports as a 382-to-0 step, over many frames at codes 0, 10 and 15. If the reload value were off by one, these counts would differ, and the scroll would run too fast or too slow. It drives a run where `frameStart` falls on the same cycle as `lineStart`. A design that passed the new request straight to the armed state there would wrap early one line too soon. A design that let `lineStart` clear the request would lose the early wrap altogether. It also changes the position code partway through a long rate period. A design that read the code on every frame would then fire extra early wraps.

// File: rtl/scroll_pkg.sv
package scroll_pkg;
  // Strobes from the rate control to the position datapath
  typedef struct packed {
    logic useShort;   // next wrap point is one count early
  } ctlStrobe_t;
endpackage

// File: rtl/scroll_rate_ctrl.sv
module scroll_rate_ctrl
  import scroll_pkg::*;
#(
  parameter int POS_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineStart,
  input  logic             frameStart,
  input  logic [POS_W-1:0] posCode,
  input  logic             shortTaken,
  output ctlStrobe_t       ctl
);
  localparam logic [POS_W-1:0] RATE_MAX = {POS_W{1'b1}};

  logic [POS_W-1:0] rateCnt;
  logic             pending;
  logic             armed;
  logic             termCnt;

  assign termCnt = frameStart && (rateCnt == '0);

  // Frame-rate programmable divider (R5, R9)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateCnt <= '0;
    end else if (frameStart) begin
      if (rateCnt == '0) rateCnt <= RATE_MAX - posCode;
      else               rateCnt <= rateCnt - 1'b1;
    end
  end

  // Request hand-off: pending -> armed at line start (R6, R7), consumed at wrap (R4)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      armed   <= 1'b0;
    end else begin
      if (termCnt)        pending <= 1'b1;
      else if (lineStart) pending <= 1'b0;

      if (lineStart)       armed <= pending;
      else if (shortTaken) armed <= 1'b0;
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.useShort = armed;
  end
endmodule

// File: rtl/scroll_pos_dp.sv
module scroll_pos_dp
  import scroll_pkg::*;
#(
  parameter int LINE_LEN = 384,
  parameter int CNT_W    = $clog2(LINE_LEN),
  parameter int DASH_LO  = 2,
  parameter int DASH_HI  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       ctl,
  output logic             shortTaken,
  output logic [CNT_W-1:0] trackPos,
  output logic             trackPix
);
  localparam logic [CNT_W-1:0] LAST_FULL  = CNT_W'(LINE_LEN - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(LINE_LEN - 2);

  logic wrapNow;

  assign shortTaken = ctl.useShort && (trackPos == LAST_SHORT);
  assign wrapNow    = shortTaken || (trackPos == LAST_FULL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        trackPos <= '0;
    else if (wrapNow) trackPos <= '0;
    else              trackPos <= trackPos + 1'b1;
  end

  assign trackPix = (trackPos[DASH_HI:DASH_LO] == '0);
endmodule

// File: rtl/scroll_pos_counter.sv
module scroll_pos_counter
  import scroll_pkg::*;
#(
  parameter int LINE_LEN = 384,
  parameter int POS_W    = 4,
  parameter int CNT_W    = $clog2(LINE_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineStart,
  input  logic             frameStart,
  input  logic [POS_W-1:0] posCode,
  output logic [CNT_W-1:0] trackPos,
  output logic             trackPix
);
  ctlStrobe_t ctl;
  logic       shortTaken;

  scroll_rate_ctrl #(.POS_W(POS_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .lineStart (lineStart),
    .frameStart(frameStart),
    .posCode   (posCode),
    .shortTaken(shortTaken),
    .ctl       (ctl)
  );

  scroll_pos_dp #(.LINE_LEN(LINE_LEN), .CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .shortTaken(shortTaken),
    .trackPos  (trackPos),
    .trackPix  (trackPix)
  );
endmodule

// File: rtl/scroll_pos_checker.sv
module scroll_pos_checker #(
  parameter int LINE_LEN = 384,
  parameter int CNT_W    = $clog2(LINE_LEN)
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] trackPos,
  input logic             useShort
);
  localparam logic [CNT_W-1:0] LAST_FULL  = CNT_W'(LINE_LEN - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(LINE_LEN - 2);

  logic live;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) live <= 1'b0;
    else       live <= 1'b1;
  end

  a_r2_in_range: assert property (@(posedge clk) disable iff (!rstN)
    trackPos < CNT_W'(LINE_LEN));

  a_r2_step: assert property (@(posedge clk) disable iff (!rstN || !live)
    (trackPos != '0) |-> (trackPos == CNT_W'($past(trackPos) + 1'b1)));

  a_r3_full_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (trackPos == LAST_FULL) |=> (trackPos == '0));

  a_r3_no_early_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (trackPos == LAST_SHORT && !useShort) |=> (trackPos == LAST_FULL));

  a_r4_short_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (trackPos == LAST_SHORT && useShort) |=> (trackPos == '0));
endmodule

bind scroll_pos_counter scroll_pos_checker #(.LINE_LEN(LINE_LEN), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .trackPos(trackPos),
  .useShort(ctl.useShort)
);

// File: tb/test_scroll_pos_counter.sv
module test_scroll_pos_counter;
  localparam int CLK_PERIOD = 10;
  localparam int LINE = 384;
  localparam int LPF  = 2;      // lines per frame in every run

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineStart = 1'b0;
  logic       frameStart = 1'b0;
  logic [3:0] posCode = 4'd0;
  logic [8:0] trackPos;
  logic       trackPix;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int shorts = 0;
  int prevPos = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural reference state
  int mCount = 0, mRate = 0;
  bit mPend = 0, mArmed = 0;

  scroll_pos_counter i_scroll_pos_counter (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .frameStart(frameStart),
    .posCode(posCode), .trackPos(trackPos), .trackPix(trackPix)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mCount = 0; mRate = 0; mPend = 0; mArmed = 0;
    end else begin
      bit tk, tc, np, na;
      int nc, nr;
      tk = mArmed && (mCount == LINE - 2);
      nc = (mCount == LINE - 1 || tk) ? 0 : mCount + 1;
      tc = frameStart && (mRate == 0);
      nr = frameStart ? ((mRate == 0) ? 15 - int'(posCode) : mRate - 1) : mRate;
      np = tc ? 1'b1 : (lineStart ? 1'b0 : mPend);
      na = lineStart ? mPend : (tk ? 1'b0 : mArmed);
      mCount = nc; mRate = nr; mPend = np; mArmed = na;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one clock: drive after a falling edge, compare at the next falling edge
  task automatic step(input bit ls, input bit fs);
    lineStart = ls; frameStart = fs;
    @(negedge clk);
    check(int'(trackPos) == mCount, "trackPos (R2/R3/R4)", int'(trackPos), mCount);
    check(trackPix == (((mCount >> 2) & 7) == 0), "trackPix (R8)",
          int'(trackPix), int'(((mCount >> 2) & 7) == 0));
    if (prevPos == LINE - 2 && trackPos == 0) shorts++;
    prevPos = int'(trackPos);
  endtask

  task automatic doReset();
    lineStart = 0; frameStart = 0; rstN = 0;
    @(negedge clk); @(negedge clk);
    check(trackPos == 0, "reset trackPos R1", int'(trackPos), 0);
    check(trackPix == 1'b1, "reset trackPix R1", int'(trackPix), 1);
    prevPos = 0; shorts = 0;
    rstN = 1;
    @(negedge clk);
    check(int'(trackPos) == mCount, "first count R2", int'(trackPos), mCount);
  endtask

  task automatic runFrames(input int nFrames, input bit coincide);
    for (int f = 0; f < nFrames; f++)
      for (int l = 0; l < LPF; l++)
        for (int c = 0; c < LINE; c++)
          step(c == 0, (l == 0) && (c == (coincide ? 0 : 5)));
  endtask

  task automatic flush();
    for (int l = 0; l < 3; l++)
      for (int c = 0; c < LINE; c++)
        step(c == 0, 1'b0);
  endtask

  task automatic expectShorts(input int exp, input string what);
    check(shorts == exp, what, shorts, exp);
  endtask

  initial begin
    @(negedge clk);
    tag = "R1"; posCode = 4'd15;
    doReset();

    tag = "R5"; posCode = 4'd15;
    runFrames(4, 1'b0); flush();
    expectShorts(4, "code 15 early wraps R5 R6");

    doReset(); tag = "R5"; posCode = 4'd0;
    runFrames(17, 1'b0); flush();
    expectShorts(2, "code 0 early wraps R5");

    doReset(); tag = "R5"; posCode = 4'd10;
    runFrames(12, 1'b0); flush();
    expectShorts(2, "code 10 early wraps R5");

    doReset(); tag = "R7"; posCode = 4'd15;
    runFrames(3, 1'b1); flush();
    expectShorts(3, "coincident strobes R7");

    doReset(); tag = "R9"; posCode = 4'd0;
    runFrames(1, 1'b0);
    posCode = 4'd15;
    runFrames(10, 1'b0); flush();
    expectShorts(1, "mid-period code change R9");

    tag = "R3";
    for (int c = 0; c < 2 * LINE; c++) step(1'b0, 1'b0);
    expectShorts(1, "no early wrap when idle R3");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (!done && cycles > 190000) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule